// File: doc/BRIEF.md
# Misaligned Access Exception Frame Sequencer

This block watches the access a processor core is about to make and raises an alignment fault when a word or longword access, or an instruction fetch, targets an odd byte address. It then takes over a 16-bit memory port and pushes a seven-word fault frame onto the supervisor stack. The frame records the program counter, the status register, the instruction register, the faulting address and a status word that describes the access. The status word states whether the access was a fetch, a data read or a data write, and whether the core was privileged at the time.

Once the frame is stacked, the block reads the handler address from the vector table with two 16-bit reads. It then spends a fixed penalty of extra cycles and raises a one-cycle completion pulse. With that pulse it presents the handler PC, the new status register (with the supervisor bit set) and the lowered supervisor stack pointer. The core loads these values and resumes at the handler. If the core was in user mode, it is expected to treat the supervisor stack pointer as the active stack from then on. The block always stacks on the supervisor pointer, whatever the mode.

Top module: `aerr_seq`

## Requirements
- R1: A fault starts only when `trig` is high in an idle cycle, `acc_size` is word (1) or long (2), and `acc_addr` bit 0 is 1. A byte access (0) or an even address starts nothing: `busy` and `mem_req` stay low.
- R2: The frame goes on the supervisor stack in both user and supervisor mode. The first write is at `cur_ssp - 2`, each following write is 2 bytes lower, and there are seven writes. `new_ssp` is `cur_ssp - 14`.
- R3: The words are written in this order: PC low half, PC high half, SR, IR, faulting address low half, faulting address high half, status word. SR is the value held before the fault.
- R4: The status word is zero except for these bits. Bit 2 is SR bit 13, the supervisor state. Bit 4 is set for a fetch or a data read. Bit 1 is set for a fetch (`acc_fetch`=1). Bit 0 is set for a data access. So the word is 0x12, 0x11 or 0x01, plus 0x04 in supervisor mode; `acc_write` is ignored for fetches.
- R5: `new_sr` equals the stacked SR with bit 13 set.
- R6: After the frame, the block makes two reads: byte address 12 (the high half) and then byte address 14 (the low half). `new_pc` is {high, low}.
- R7: Exactly 18 cycles pass between the cycle of the final vector-read handshake and the cycle in which `done` is high, so `done` is high in the 19th cycle after that handshake.
- R8: `done` is a one-cycle pulse, and `new_pc`, `new_sr` and `new_ssp` are valid while it is high. A trigger that arrives while `busy` is high, including the `done` cycle, is ignored and produces no memory traffic.
- R9: A request holds its address, direction and data until `mem_ack` arrives. Every request address is even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig | input | 1 | Access qualifier; the access fields are sampled with it |
| acc_addr | input | 32 | Byte address of the access |
| acc_size | input | 2 | 0 byte, 1 word, 2 long |
| acc_write | input | 1 | 1 for a data write |
| acc_fetch | input | 1 | 1 for an instruction fetch |
| cur_sr | input | 16 | Status register at the time of the access |
| cur_pc | input | 32 | Last prefetch address |
| cur_ir | input | 16 | Instruction register |
| cur_ssp | input | 32 | Supervisor stack pointer |
| busy | output | 1 | Sequence in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Even byte address of the request |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Completes the current request this cycle |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` on reads |
| done | output | 1 | One-cycle completion pulse |
| new_pc | output | 32 | Handler PC |
| new_sr | output | 16 | SR with supervisor bit set |
| new_ssp | output | 32 | Supervisor stack pointer after stacking |

## Verification
Two things can fall in the same cycle: a new faulting trigger, and the completion of the current sequence (or a handshake in the middle of it). The bench provokes the first case by waiting until `done` is visible and then driving a faulting trigger in that same cycle. It provokes the second by firing a trigger while the frame writes are still being acknowledged. In both cases it judges the result by transaction. Any memory request that the reference queue did not predict fails, and so does any change to the expected frame contents.

// File: rtl/aerr_pkg.sv
// Shared types and codes for the alignment fault sequencer.
// Assumes a byte-addressed memory with a 16-bit data port.
package aerr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_WAIT,
        ST_DONE
    } seq_state_t;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;
    localparam logic [1:0] SZ_LONG = 2'd2;

    localparam int SR_S_BIT = 13;
endpackage

// File: rtl/aerr_detect.sv
// Combinational fault detector and access status word builder.
// Assumes: only the low address bits matter for alignment; byte accesses never fault.
module aerr_detect #(
    parameter logic [1:0] ALIGN_MASK = 2'b01,
    parameter int          DW         = 16
) (
    input  logic [1:0]    addr_lo,
    input  logic [1:0]    acc_size,
    input  logic          acc_write,
    input  logic          acc_fetch,
    input  logic          sr_s,
    output logic          fault,
    output logic [DW-1:0] status
);
    import aerr_pkg::*;

    logic multi_byte;
    logic is_read;

    // Flag word/long accesses whose low address bits break alignment.
    always_comb begin
        multi_byte = (acc_size == SZ_WORD) || (acc_size == SZ_LONG);
        fault      = multi_byte && ((addr_lo & ALIGN_MASK) != 2'b00);
    end

    // Compose the access status word: read, privilege, fetch and data bits.
    always_comb begin
        is_read   = acc_fetch || !acc_write;
        status    = '0;
        status[4] = is_read;
        status[2] = sr_s;
        status[1] = acc_fetch;
        status[0] = !acc_fetch;
    end
endmodule

// File: rtl/aerr_frame.sv
// Frame holding registers: captures the faulting context and serves the
// stacked word and its address for a given write step.
// Assumes AW is a multiple of DW; wide values are written low half first.
module aerr_frame #(
    parameter int AW = 32,
    parameter int DW = 16,
    parameter int FW = 7,
    parameter int SW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] pc,
    input  logic [DW-1:0] sr,
    input  logic [DW-1:0] ir,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] status,
    input  logic [AW-1:0] ssp,
    input  logic [SW-1:0] step,
    output logic [DW-1:0] word,
    output logic [AW-1:0] waddr,
    output logic [DW-1:0] sr_out,
    output logic [AW-1:0] ssp_out
);
    import aerr_pkg::*;

    localparam int HALVES = AW / DW;
    localparam int BYTES  = DW / 8;

    logic [AW-1:0] pc_q, addr_q, ssp_q;
    logic [DW-1:0] sr_q, ir_q, st_q;
    logic [DW-1:0] words [FW];

    // Capture the faulting context when a sequence starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            addr_q <= '0;
            ssp_q  <= '0;
            sr_q   <= '0;
            ir_q   <= '0;
            st_q   <= '0;
        end else if (load) begin
            pc_q   <= pc;
            addr_q <= addr;
            ssp_q  <= ssp;
            sr_q   <= sr;
            ir_q   <= ir;
            st_q   <= status;
        end
    end

    // Lay out the frame words in write order.
    for (genvar k = 0; k < HALVES; k++) begin : g_halves
        assign words[k]          = pc_q[k*DW +: DW];
        assign words[HALVES+2+k] = addr_q[k*DW +: DW];
    end
    assign words[HALVES]      = sr_q;
    assign words[HALVES+1]    = ir_q;
    assign words[2*HALVES+2]  = st_q;

    // Select the word and its predecremented stack address for this step.
    always_comb begin
        word  = words[step];
        waddr = ssp_q - AW'((32'(step) + 1) * BYTES);
    end

    // Results handed back to the core.
    always_comb begin
        sr_out           = sr_q;
        sr_out[SR_S_BIT] = 1'b1;
        ssp_out          = ssp_q - AW'(FW * BYTES);
    end
endmodule

// File: rtl/aerr_ctrl.sv
// Sequencer control: steps through frame writes, vector reads and the
// fixed penalty, then pulses done. Triggers are honoured only when idle.
// Assumes mem_ack completes one transfer per cycle in which it is high.
module aerr_ctrl #(
    parameter int AW        = 32,
    parameter int DW        = 16,
    parameter int FW        = 7,
    parameter int SW        = 3,
    parameter int VEC_NUM   = 3,
    parameter int EXTRA_CYC = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          load,
    output logic          busy,
    output logic          done,
    output logic          mem_req,
    output logic          mem_we,
    output logic [SW-1:0] step,
    output logic [AW-1:0] rd_addr,
    output logic [AW-1:0] vec_pc
);
    import aerr_pkg::*;

    localparam int HALVES = AW / DW;
    localparam int BYTES  = DW / 8;
    localparam int CW     = $clog2(EXTRA_CYC + 1);
    localparam logic [AW-1:0] VEC_ADDR = AW'(VEC_NUM * 4);

    seq_state_t    state;
    logic [CW-1:0] cnt;
    logic [AW-1:0] pc_acc;

    // Decode outputs from the current state.
    always_comb begin
        load    = (state == ST_IDLE) && start;
        busy    = (state != ST_IDLE);
        done    = (state == ST_DONE);
        mem_req = (state == ST_WRITE) || (state == ST_READ);
        mem_we  = (state == ST_WRITE);
        rd_addr = VEC_ADDR + AW'(32'(step) * BYTES);
        vec_pc  = pc_acc;
    end

    // Advance the sequence and collect the vector halves, high first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            step   <= '0;
            cnt    <= '0;
            pc_acc <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state <= ST_WRITE;
                    step  <= '0;
                end
                ST_WRITE: if (mem_ack) begin
                    if (step == SW'(FW - 1)) begin
                        state <= ST_READ;
                        step  <= '0;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                ST_READ: if (mem_ack) begin
                    pc_acc <= {pc_acc[AW-DW-1:0], mem_rdata};
                    if (step == SW'(HALVES - 1)) begin
                        state <= ST_WAIT;
                        step  <= '0;
                        cnt   <= CW'(EXTRA_CYC - 1);
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (cnt == '0) state <= ST_DONE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8: completion is a single-cycle pulse.
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1: an accepted fault begins with a frame write in the next cycle.
    a_r1_start_write: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (mem_req && mem_we));

    // R8: a trigger during the done cycle does not restart the sequence.
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

// File: rtl/aerr_seq.sv
// Top level: alignment fault detection plus frame stacking and vector fetch
// over a 16-bit memory port. Assumes the core stalls while busy is high.
module aerr_seq #(
    parameter int          AW         = 32,
    parameter int          DW         = 16,
    parameter int          VEC_NUM    = 3,
    parameter int          EXTRA_CYC  = 18,
    parameter logic [1:0]  ALIGN_MASK = 2'b01
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig,
    input  logic [AW-1:0] acc_addr,
    input  logic [1:0]    acc_size,
    input  logic          acc_write,
    input  logic          acc_fetch,
    input  logic [DW-1:0] cur_sr,
    input  logic [AW-1:0] cur_pc,
    input  logic [DW-1:0] cur_ir,
    input  logic [AW-1:0] cur_ssp,
    output logic          busy,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          done,
    output logic [AW-1:0] new_pc,
    output logic [DW-1:0] new_sr,
    output logic [AW-1:0] new_ssp
);
    import aerr_pkg::*;

    localparam int HALVES = AW / DW;
    localparam int FW     = 2 * HALVES + 3;
    localparam int SW     = $clog2(FW);

    logic          fault, start, load;
    logic [DW-1:0] status, word;
    logic [SW-1:0] step;
    logic [AW-1:0] waddr, rd_addr;

    aerr_detect #(.ALIGN_MASK(ALIGN_MASK), .DW(DW)) i_detect (
        .addr_lo   (acc_addr[1:0]),
        .acc_size  (acc_size),
        .acc_write (acc_write),
        .acc_fetch (acc_fetch),
        .sr_s      (cur_sr[SR_S_BIT]),
        .fault     (fault),
        .status    (status)
    );

    // Qualify the detector result with the trigger.
    assign start = trig && fault;

    aerr_frame #(.AW(AW), .DW(DW), .FW(FW), .SW(SW)) i_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .pc      (cur_pc),
        .sr      (cur_sr),
        .ir      (cur_ir),
        .addr    (acc_addr),
        .status  (status),
        .ssp     (cur_ssp),
        .step    (step),
        .word    (word),
        .waddr   (waddr),
        .sr_out  (new_sr),
        .ssp_out (new_ssp)
    );

    aerr_ctrl #(.AW(AW), .DW(DW), .FW(FW), .SW(SW),
                .VEC_NUM(VEC_NUM), .EXTRA_CYC(EXTRA_CYC)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .load      (load),
        .busy      (busy),
        .done      (done),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .step      (step),
        .rd_addr   (rd_addr),
        .vec_pc    (new_pc)
    );

    // Steer the memory port between frame writes and vector reads.
    always_comb begin
        mem_addr  = mem_we ? waddr : rd_addr;
        mem_wdata = mem_we ? word  : '0;
    end

    // R9: an unacknowledged request holds its address, direction and data.
    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_wdata)));

    // R9: request addresses are always even.
    a_r9_even_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[0] == 1'b0));

    // R2: each frame write but the last is followed by one two bytes lower.
    a_r2_descend: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_we && (mem_addr != new_ssp))
        |=> (mem_we && (mem_addr == $past(mem_addr) - AW'(2))));

    // R5: the handed-back SR always has the supervisor bit set.
    a_r5_sr_super: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> new_sr[SR_S_BIT]);
endmodule

// File: tb/test_aerr_seq.sv
module test_aerr_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic        acc_write = 1'b0;
    logic        acc_fetch = 1'b0;
    logic [15:0] cur_sr = '0;
    logic [31:0] cur_pc = '0;
    logic [15:0] cur_ir = '0;
    logic [31:0] cur_ssp = '0;
    logic        busy, mem_req, mem_we, done;
    logic [31:0] mem_addr, new_pc, new_ssp;
    logic [15:0] mem_wdata, new_sr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_rd_cyc = 0;
    int wait_ctr = 0;
    int lat_seed = 0;
    int done_count = 0;

    logic        q_we[$];
    logic [31:0] q_addr[$];
    logic [15:0] q_data[$];
    logic [31:0] exp_pc, exp_ssp;
    logic [15:0] exp_sr;
    logic [15:0] vec_hi = 16'h0000, vec_lo = 16'h0000;

    always #(CLK_PERIOD/2) clk = ~clk;

    aerr_seq i_aerr_seq (
        .clk(clk), .rst_n(rst_n), .trig(trig), .acc_addr(acc_addr),
        .acc_size(acc_size), .acc_write(acc_write), .acc_fetch(acc_fetch),
        .cur_sr(cur_sr), .cur_pc(cur_pc), .cur_ir(cur_ir), .cur_ssp(cur_ssp),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .new_pc(new_pc), .new_sr(new_sr), .new_ssp(new_ssp)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Memory model and per-clock reference comparison.
    always @(negedge clk) begin
        cyc++;
        mem_ack = 1'b0;
        if (rst_n && mem_req) begin
            if (wait_ctr > 0) begin
                wait_ctr--;
            end else begin
                mem_ack = 1'b1;
                lat_seed++;
                wait_ctr = (lat_seed * 7) % 3;
                if (q_we.size() == 0) begin
                    check(1'b0, "R8", "unexpected request", mem_addr, 32'h0);
                end else begin
                    automatic logic        e_we = q_we.pop_front();
                    automatic logic [31:0] e_ad = q_addr.pop_front();
                    automatic logic [15:0] e_dt = q_data.pop_front();
                    check(mem_we == e_we, "R3", "direction", {31'h0, mem_we}, {31'h0, e_we});
                    check(mem_addr == e_ad, e_we ? "R2" : "R6", "address", mem_addr, e_ad);
                    if (e_we)
                        check(mem_wdata == e_dt, "R3", "write data", {16'h0, mem_wdata}, {16'h0, e_dt});
                    if (!mem_we) begin
                        mem_rdata = (mem_addr == 32'd12) ? vec_hi : vec_lo;
                        if (mem_addr == 32'd14) last_rd_cyc = cyc;
                    end
                end
            end
        end
        if (rst_n && done) begin
            done_count++;
            check(cyc - last_rd_cyc == 19, "R7", "penalty gap", cyc - last_rd_cyc, 32'd19);
            check(new_pc == exp_pc, "R6", "new_pc", new_pc, exp_pc);
            check(new_sr == exp_sr, "R5", "new_sr", {16'h0, new_sr}, {16'h0, exp_sr});
            check(new_ssp == exp_ssp, "R2", "new_ssp", new_ssp, exp_ssp);
            check(q_we.size() == 0, "R3", "frame complete", q_we.size(), 32'd0);
        end
    end

    task automatic push(input logic we, input logic [31:0] a, input logic [15:0] d);
        q_we.push_back(we);
        q_addr.push_back(a);
        q_data.push_back(d);
    endtask

    // Drive one access; if it is expected to fault, queue the predicted traffic.
    task automatic fire(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                        input logic fe, input logic [15:0] sr, input logic [31:0] pc,
                        input logic [15:0] ir, input logic [31:0] ssp, input bit expect_fault);
        acc_addr = a; acc_size = sz; acc_write = wr; acc_fetch = fe;
        cur_sr = sr; cur_pc = pc; cur_ir = ir; cur_ssp = ssp;
        if (expect_fault) begin
            automatic logic [15:0] st = fe ? 16'h0012 : (wr ? 16'h0001 : 16'h0011);
            if (sr[13]) st = st | 16'h0004;                       // R4
            push(1'b1, ssp - 2,  pc[15:0]);
            push(1'b1, ssp - 4,  pc[31:16]);
            push(1'b1, ssp - 6,  sr);
            push(1'b1, ssp - 8,  ir);
            push(1'b1, ssp - 10, a[15:0]);
            push(1'b1, ssp - 12, a[31:16]);
            push(1'b1, ssp - 14, st);
            push(1'b0, 32'd12, 16'h0);
            push(1'b0, 32'd14, 16'h0);
            exp_pc = {vec_hi, vec_lo};
            exp_sr = sr | 16'h2000;
            exp_ssp = ssp - 14;
        end
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic wait_done();
        automatic int n = done_count;
        while (done_count == n) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic expect_quiet(input string req);
        repeat (5) begin
            @(negedge clk);
            check(!busy && !mem_req, req, "stays idle", {30'h0, busy, mem_req}, 32'h0);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !mem_req && !done, "R8", "reset state", {29'h0, busy, mem_req, done}, 32'h0);

        // R1: byte at odd address and aligned word/long do not fault
        fire(32'h0000_1001, 2'd0, 1'b0, 1'b0, 16'h0000, 32'h400, 16'h1234, 32'h8000, 0);
        expect_quiet("R1");
        fire(32'h0000_1002, 2'd1, 1'b1, 1'b0, 16'h0000, 32'h400, 16'h1234, 32'h8000, 0);
        expect_quiet("R1");
        fire(32'h0000_1004, 2'd2, 1'b0, 1'b1, 16'h2000, 32'h400, 16'h1234, 32'h8000, 0);
        expect_quiet("R1");

        // R4: user-mode long data write, status 0x01
        vec_hi = 16'h0001; vec_lo = 16'h2340;
        fire(32'h00AB_CDEF, 2'd2, 1'b1, 1'b0, 16'h0715, 32'h0002_1000, 16'h2F3C, 32'h0000_9000, 1);
        wait_done();

        // R4: supervisor word data read, status 0x15
        vec_hi = 16'h00FF; vec_lo = 16'h8000;
        fire(32'h0012_3457, 2'd1, 1'b0, 1'b0, 16'h2704, 32'h0003_0010, 16'h3010, 32'h0001_0000, 1);
        wait_done();

        // R4: user-mode odd fetch, status 0x12 (write flag ignored)
        vec_hi = 16'h0000; vec_lo = 16'h0500;
        fire(32'h0000_4321, 2'd1, 1'b1, 1'b1, 16'h001F, 32'h0000_4321, 16'h4E71, 32'h0000_7FFE, 1);
        wait_done();

        // R4: supervisor odd fetch, status 0x16; trigger during frame ignored (R8)
        vec_hi = 16'hDEAD; vec_lo = 16'hBEEE;
        fire(32'h0000_0103, 2'd1, 1'b0, 1'b1, 16'h2300, 32'h0000_0103, 16'h0000, 32'h0000_2000, 1);
        repeat (3) @(negedge clk);
        fire(32'h0000_5555, 2'd2, 1'b1, 1'b0, 16'h0000, 32'h0, 16'h0, 32'h0000_6000, 0);
        wait_done();

        // R8: trigger in the same cycle as done is ignored
        vec_hi = 16'h0000; vec_lo = 16'h0C00;
        fire(32'h0000_0FF1, 2'd1, 1'b0, 1'b0, 16'h0000, 32'h0000_0200, 16'hABCD, 32'h0000_3000, 1);
        do @(negedge clk); while (!done);
        acc_addr = 32'h0000_0777; acc_size = 2'd1; trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        expect_quiet("R8");

        // R1: a fresh fault after idle is accepted again
        vec_hi = 16'h0000; vec_lo = 16'h1000;
        fire(32'h0000_0779, 2'd2, 1'b0, 1'b0, 16'h2000, 32'h0000_0300, 16'h1111, 32'h0000_4000, 1);
        wait_done();
        check(q_we.size() == 0, "R1", "all traffic seen", q_we.size(), 32'd0);
        check(done_count == 6, "R8", "done pulses", done_count, 32'd6);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule